// File: doc/BRIEF.md
# FIFO-Bridged Accelerator Transaction Controller

This block sequences one transaction at a time between a processor-facing input FIFO, a user processing core and a processor-facing output FIFO. It pulls a request of a fixed number of 32-bit words from the input FIFO and hands each word, with its position, to the core. It then signals the core to start and idles until the core reports completion. After that it drains a fixed number of result words from the core into the output FIFO. The three phases run strictly one after another, so the input FIFO and the output FIFO are never accessed in the same cycle.

The input FIFO is a standard read-latency-one FIFO. Its data is valid on the cycle after the read enable. The controller drives the core's write side combinationally from that data. It reads the core's results from registered storage that it addresses by index. Request and result lengths are parameters.

Top module: `fifo_accel_ctrl`

## Requirements
- R1: Reset places the controller in the receive phase with both FIFO enables and the start pulse low, and clears the word counters. Even while reset is held, no read is issued. A request cut short by reset is discarded, and the next request starts again at word index 0.
- R2: `in_rd_en` is high only in the receive phase, only while `in_empty` is low, and only while fewer than REQ_WORDS reads of the current request have been issued.
- R3: One cycle after each read enable, `core_wr_en` is high and `core_wr_data` equals the FIFO word. `core_wr_idx` runs 0, 1, ... REQ_WORDS-1 in read order. At all other times `core_wr_en` is low.
- R4: The cycle after the word with index REQ_WORDS-1 is presented, `core_go` is high for exactly one cycle and the controller enters the wait phase.
- R5: In the wait phase there is no read and no write until `core_done` is high. The next cycle is the send phase. A `core_done` seen during receive or send has no effect.
- R6: `out_wr_en` is high exactly when the controller is in the send phase and `out_full` is low. `out_data` is the core result selected by `core_rd_idx`. That index runs 0 ... RSP_WORDS-1 and advances once per accepted write.
- R7: After the RSP_WORDS-th write the controller is back in the receive phase, and it takes the next request from the input FIFO without any other stimulus.
- R8: A read and a write never occur in the same cycle. Exactly REQ_WORDS reads are issued per request.
- R9: Words pass through unchanged at their full 32-bit width in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_empty | input | 1 | Input FIFO holds no word |
| in_rd_en | output | 1 | Pop one word from the input FIFO |
| in_data | input | DW | Input FIFO data, valid the cycle after a pop |
| core_wr_en | output | 1 | A request word is presented to the core |
| core_wr_idx | output | IW | Position of the presented word in the request |
| core_wr_data | output | DW | Presented request word |
| core_go | output | 1 | One-cycle start pulse after the full request |
| core_done | input | 1 | Core reports its results are ready |
| core_rd_idx | output | OW | Index of the result word being sent |
| core_res_word | input | DW | Registered core result at `core_rd_idx` |
| out_full | input | 1 | Output FIFO cannot accept a word |
| out_wr_en | output | 1 | Push `out_data` into the output FIFO |
| out_data | output | DW | Result word being pushed |

## Verification
A read enable is followed, one cycle later, by the presented word with its index. The start pulse comes one cycle after the last request word. Output writes and their data are combinational on `out_full` and the current result index, so they take effect in the same cycle. Phase changes after done or after the last write show up one cycle later. The bench drives every input on the rising edge or between edges. It compares presented words, indices and the start pulse at the following falling edge against what the input FIFO model popped one cycle earlier. Result words are compared in the order the output FIFO model captured them, against sums and XORs listed per vector. Stall windows, held-full windows and early done pulses are checked through the read and write counts of the FIFO models over fixed cycle spans.

// File: rtl/fab_pkg.sv
package fab_pkg;

  typedef enum logic [1:0] {
    PH_RECV = 2'd0,
    PH_WAIT = 2'd1,
    PH_SEND = 2'd2
  } phase_e;

  // True when a counter value sits on its final position.
  function automatic logic count_is(input logic [31:0] value, input logic [31:0] target);
    return value == target;
  endfunction

  // Counter step with wrap to zero after the final position.
  function automatic logic [31:0] advance(input logic [31:0] value, input logic step,
                                          input logic wrap);
    if (!step) return value;
    if (wrap) return 32'd0;
    return value + 32'd1;
  endfunction

  // Phase sequencing: receive, then wait, then send, then receive again.
  function automatic phase_e next_phase(input phase_e cur, input logic recv_last,
                                        input logic done, input logic send_last);
    case (cur)
      PH_RECV: return recv_last ? PH_WAIT : PH_RECV;
      PH_WAIT: return done ? PH_SEND : PH_WAIT;
      PH_SEND: return send_last ? PH_RECV : PH_SEND;
      default: return PH_RECV;
    endcase
  endfunction

endpackage

// File: rtl/fab_word_counter.sv
module fab_word_counter
  import fab_pkg::*;
#(
  parameter int unsigned LIMIT = 4,
  parameter int unsigned CW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [CW-1:0] count,
  output logic          at_last
);

  assign at_last = count_is(32'(count), LIMIT - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= CW'(advance(32'(count), step, at_last));
  end

endmodule

// File: rtl/fab_phase_fsm.sv
module fab_phase_fsm
  import fab_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   recv_last,
  input  logic   core_done,
  input  logic   send_last,
  output phase_e phase,
  output logic   go
);

  phase_e phase_nx;

  always_comb phase_nx = next_phase(phase, recv_last, core_done, send_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_RECV;
      go    <= 1'b0;
    end else begin
      phase <= phase_nx;
      go    <= recv_last;
    end
  end

endmodule

// File: rtl/fab_recv_path.sv
module fab_recv_path
  import fab_pkg::*;
#(
  parameter int unsigned REQ_WORDS = 4,
  parameter int unsigned DW        = 32,
  parameter int unsigned IW        = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_e        phase,
  input  logic          in_empty,
  output logic          in_rd_en,
  input  logic [DW-1:0] in_data,
  output logic          core_wr_en,
  output logic [IW-1:0] core_wr_idx,
  output logic [DW-1:0] core_wr_data,
  output logic          recv_last
);

  logic pend;
  logic land_last;

  // Words issued = words landed + the one in flight; stop once the last is in flight.
  assign recv_last = pend && land_last;
  assign in_rd_en  = rst_n && (phase == PH_RECV) && !in_empty && !recv_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= in_rd_en;
  end

  fab_word_counter #(.LIMIT(REQ_WORDS), .CW(IW)) u_land_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (pend),
    .count  (core_wr_idx),
    .at_last(land_last)
  );

  assign core_wr_en   = pend;
  assign core_wr_data = in_data;

endmodule

// File: rtl/fab_send_path.sv
module fab_send_path
  import fab_pkg::*;
#(
  parameter int unsigned RSP_WORDS = 2,
  parameter int unsigned DW        = 32,
  parameter int unsigned OW        = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_e        phase,
  input  logic          out_full,
  output logic          out_wr_en,
  output logic [DW-1:0] out_data,
  output logic [OW-1:0] core_rd_idx,
  input  logic [DW-1:0] core_res_word,
  output logic          send_last
);

  logic idx_last;

  assign out_wr_en = (phase == PH_SEND) && !out_full;
  assign out_data  = core_res_word;
  assign send_last = out_wr_en && idx_last;

  fab_word_counter #(.LIMIT(RSP_WORDS), .CW(OW)) u_send_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (out_wr_en),
    .count  (core_rd_idx),
    .at_last(idx_last)
  );

endmodule

// File: rtl/fifo_accel_ctrl.sv
module fifo_accel_ctrl
  import fab_pkg::*;
#(
  parameter  int unsigned REQ_WORDS = 4,
  parameter  int unsigned RSP_WORDS = 2,
  parameter  int unsigned DW        = 32,
  localparam int unsigned IW        = (REQ_WORDS > 1) ? $clog2(REQ_WORDS) : 1,
  localparam int unsigned OW        = (RSP_WORDS > 1) ? $clog2(RSP_WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_empty,
  output logic          in_rd_en,
  input  logic [DW-1:0] in_data,
  output logic          core_wr_en,
  output logic [IW-1:0] core_wr_idx,
  output logic [DW-1:0] core_wr_data,
  output logic          core_go,
  input  logic          core_done,
  output logic [OW-1:0] core_rd_idx,
  input  logic [DW-1:0] core_res_word,
  input  logic          out_full,
  output logic          out_wr_en,
  output logic [DW-1:0] out_data
);

  phase_e phase;
  logic   recv_last;
  logic   send_last;

  fab_phase_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .recv_last(recv_last),
    .core_done(core_done),
    .send_last(send_last),
    .phase    (phase),
    .go       (core_go)
  );

  fab_recv_path #(.REQ_WORDS(REQ_WORDS), .DW(DW), .IW(IW)) u_recv (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase       (phase),
    .in_empty    (in_empty),
    .in_rd_en    (in_rd_en),
    .in_data     (in_data),
    .core_wr_en  (core_wr_en),
    .core_wr_idx (core_wr_idx),
    .core_wr_data(core_wr_data),
    .recv_last   (recv_last)
  );

  fab_send_path #(.RSP_WORDS(RSP_WORDS), .DW(DW), .OW(OW)) u_send (
    .clk          (clk),
    .rst_n        (rst_n),
    .phase        (phase),
    .out_full     (out_full),
    .out_wr_en    (out_wr_en),
    .out_data     (out_data),
    .core_rd_idx  (core_rd_idx),
    .core_res_word(core_res_word),
    .send_last    (send_last)
  );

endmodule

// File: rtl/fab_ctrl_chk.sv
module fab_ctrl_chk
  import fab_pkg::*;
#(
  parameter int unsigned REQ_WORDS = 4,
  parameter int unsigned RSP_WORDS = 2,
  parameter int unsigned IW        = 2,
  parameter int unsigned OW        = 1
) (
  input logic          clk,
  input logic          rst_n,
  input phase_e        phase,
  input logic          in_empty,
  input logic          in_rd_en,
  input logic          out_full,
  input logic          out_wr_en,
  input logic          core_wr_en,
  input logic [IW-1:0] core_wr_idx,
  input logic [OW-1:0] core_rd_idx,
  input logic          core_go,
  input logic          core_done
);

  // R2
  rd_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_rd_en |-> !in_empty);

  // R8
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_rd_en && out_wr_en));

  // R6
  wr_needs_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr_en |-> !out_full);

  // R3
  word_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_rd_en |=> core_wr_en);

  // R4
  go_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_wr_en && core_wr_idx == IW'(REQ_WORDS - 1)) |=> (core_go && phase == PH_WAIT));

  // R4
  go_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_go |=> !core_go);

  // R5
  wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WAIT) |-> (!in_rd_en && !out_wr_en));

  // R5
  done_leaves_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WAIT && core_done) |=> (phase == PH_SEND));

  // R7
  send_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_wr_en && core_rd_idx == OW'(RSP_WORDS - 1)) |=> (phase == PH_RECV));

endmodule

bind fifo_accel_ctrl fab_ctrl_chk #(
  .REQ_WORDS(REQ_WORDS), .RSP_WORDS(RSP_WORDS), .IW(IW), .OW(OW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .phase      (phase),
  .in_empty   (in_empty),
  .in_rd_en   (in_rd_en),
  .out_full   (out_full),
  .out_wr_en  (out_wr_en),
  .core_wr_en (core_wr_en),
  .core_wr_idx(core_wr_idx),
  .core_rd_idx(core_rd_idx),
  .core_go    (core_go),
  .core_done  (core_done)
);

// File: tb/tb_fifo_accel_ctrl.sv
module tb_fifo_accel_ctrl;

  localparam int REQ = 4;
  localparam int RSP = 2;

  typedef struct packed {
    logic [31:0] w0, w1, w2, w3;
    logic [31:0] r0, r1;
    logic [7:0]  gap;
    logic [7:0]  fpat;
    logic [7:0]  lat;
  } vec_t;

  // r0 = sum of the four words, r1 = XOR of the four words (stand-in core)
  localparam vec_t VECS [5] = '{
    '{32'd1, 32'd2, 32'd3, 32'd4, 32'd10, 32'd4, 8'd0, 8'h00, 8'd1},
    '{32'h10, 32'h20, 32'h40, 32'h80, 32'hF0, 32'hF0, 8'd2, 8'h55, 8'd3},
    '{32'hFFFF_FFFF, 32'd1, 32'd0, 32'd0, 32'd0, 32'hFFFF_FFFE, 8'd0, 8'h3C, 8'd6},
    '{32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'd0, 32'd2, 32'd1, 32'hFFFF_FFFD, 8'd5, 8'h00, 8'd2},
    '{32'h8000_0000, 32'h8000_0000, 32'd7, 32'd9, 32'h10, 32'hE, 8'd1, 8'hFE, 8'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_empty;
  logic        in_rd_en;
  logic [31:0] in_data;
  logic        core_wr_en;
  logic [1:0]  core_wr_idx;
  logic [31:0] core_wr_data;
  logic        core_go;
  logic        core_done;
  logic [0:0]  core_rd_idx;
  logic [31:0] core_res_word;
  logic        out_full;
  logic        out_wr_en;
  logic [31:0] out_data;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  fifo_accel_ctrl #(.REQ_WORDS(REQ), .RSP_WORDS(RSP), .DW(32)) dut (
    .clk(clk), .rst_n(rst_n), .in_empty(in_empty), .in_rd_en(in_rd_en), .in_data(in_data),
    .core_wr_en(core_wr_en), .core_wr_idx(core_wr_idx), .core_wr_data(core_wr_data),
    .core_go(core_go), .core_done(core_done), .core_rd_idx(core_rd_idx),
    .core_res_word(core_res_word), .out_full(out_full), .out_wr_en(out_wr_en),
    .out_data(out_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Input FIFO model
  logic [31:0] inq [256];
  int irp = 0;
  int iwp = 0;
  assign in_empty = (irp == iwp);
  always @(posedge clk) begin
    if (in_rd_en) begin
      in_data <= inq[irp[7:0]];
      irp <= irp + 1;
    end
  end
  task automatic push(input logic [31:0] w);
    inq[iwp[7:0]] = w;
    iwp = iwp + 1;
  endtask

  // Output FIFO model and full pattern
  logic [31:0] outq [256];
  int owp = 0;
  logic [7:0] full_pat = 8'h00;
  logic full_force = 1'b0;
  logic [2:0] cyc = 3'd0;
  always @(posedge clk) cyc <= cyc + 3'd1;
  assign out_full = full_force | full_pat[cyc];
  always @(posedge clk) begin
    if (rst_n && out_wr_en) begin
      outq[owp[7:0]] <= out_data;
      owp <= owp + 1;
    end
  end

  // Stand-in core: results registered on the start pulse, done after lat cycles
  logic [31:0] words [REQ];
  logic [31:0] res [RSP];
  int lat = 1;
  int timer = 0;
  logic done_m = 1'b0;
  logic spur = 1'b0;
  assign core_done = done_m | spur;
  assign core_res_word = res[core_rd_idx];
  always @(posedge clk) begin
    done_m <= 1'b0;
    if (!rst_n) timer <= 0;
    else begin
      if (core_wr_en) words[core_wr_idx] <= core_wr_data;
      if (core_go) begin
        res[0] <= words[0] + words[1] + words[2] + words[3];
        res[1] <= words[0] ^ words[1] ^ words[2] ^ words[3];
        timer <= lat;
      end else if (timer > 0) begin
        timer <= timer - 1;
        if (timer == 1) done_m <= 1'b1;
      end
    end
  end

  // Port monitors sampled at the falling edge
  logic        prev_rd = 1'b0;
  logic [31:0] prev_word = '0;
  logic        prev_last = 1'b0;
  int          exp_idx = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_rd = 1'b0; prev_last = 1'b0; exp_idx = 0;
    end else begin
      if (prev_rd) begin
        chk("R3 word presented", {31'd0, core_wr_en}, 32'd1);
        chk("R3 word index", {30'd0, core_wr_idx}, exp_idx);
        chk("R9 word data", core_wr_data, prev_word);
        exp_idx = (exp_idx == REQ - 1) ? 0 : exp_idx + 1;
      end else if (core_wr_en) begin
        chk("R3 spurious present", {31'd0, core_wr_en}, 32'd0);
      end
      if (prev_last || core_go) chk("R4 start pulse", {31'd0, core_go}, {31'd0, prev_last});
      if (in_rd_en) chk("R2 read when empty", {31'd0, in_empty}, 32'd0);
      if (in_rd_en || out_wr_en) chk("R8 exclusive", {31'd0, in_rd_en && out_wr_en}, 32'd0);
      if (out_wr_en) chk("R6 write when full", {31'd0, out_full}, 32'd0);
      prev_rd   = in_rd_en;
      prev_word = inq[irp[7:0]];
      prev_last = core_wr_en && (core_wr_idx == 2'(REQ - 1));
    end
  end

  task automatic wait_out(input int target);
    int n = 0;
    while (owp < target && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (owp < target) chk("R6 results timeout", owp, target);
  endtask

  task automatic run_req(input vec_t v, input string tag);
    int b = owp;
    int rb = irp;
    full_pat = v.fpat;
    lat = int'(v.lat);
    push(v.w0); repeat (int'(v.gap)) @(negedge clk);
    push(v.w1); repeat (int'(v.gap)) @(negedge clk);
    push(v.w2); repeat (int'(v.gap)) @(negedge clk);
    push(v.w3);
    wait_out(b + 2);
    chk({"R6 result0 ", tag}, outq[b[7:0]], v.r0);
    chk({"R9 result1 ", tag}, outq[8'(b + 1)], v.r1);
    chk({"R8 reads per request ", tag}, irp - rb, REQ);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk("R7 watchdog", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int b, rb, ia, oa, n;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state, no read even with data waiting
    push(32'h1234_5678);
    @(negedge clk);
    chk("R1 rd_en in reset", {31'd0, in_rd_en}, 32'd0);
    chk("R1 wr_en in reset", {31'd0, out_wr_en}, 32'd0);
    chk("R1 go in reset", {31'd0, core_go}, 32'd0);
    chk("R1 present in reset", {31'd0, core_wr_en}, 32'd0);
    iwp = irp;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 no read when empty", {31'd0, in_rd_en}, 32'd0);

    // Vector table
    for (int i = 0; i < 5; i++) run_req(VECS[i], $sformatf("vec%0d", i));
    full_pat = 8'h00;

    // R5 / R7: long wait with the next request already queued
    b = owp; rb = irp; lat = 20;
    push(VECS[0].w0); push(VECS[0].w1); push(VECS[0].w2); push(VECS[0].w3);
    push(VECS[2].w0); push(VECS[2].w1); push(VECS[2].w2); push(VECS[2].w3);
    n = 0;
    while (!core_go && n < 100) begin @(negedge clk); n++; end
    ia = irp; oa = owp;
    repeat (15) @(negedge clk);
    chk("R5 no read while waiting", irp - ia, 0);
    chk("R5 no write while waiting", owp - oa, 0);
    wait_out(b + 4);
    chk("R7 first result", outq[b[7:0]], VECS[0].r0);
    chk("R7 second request result0", outq[8'(b + 2)], VECS[2].r0);
    chk("R7 second request result1", outq[8'(b + 3)], VECS[2].r1);
    chk("R7 reads for two requests", irp - rb, 2 * REQ);

    // R5: done during receive is ignored
    b = owp; lat = 2;
    push(VECS[4].w0); push(VECS[4].w1);
    repeat (3) @(negedge clk);
    spur = 1'b1; @(negedge clk); spur = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 early done no write", owp - b, 0);
    push(VECS[4].w2); push(VECS[4].w3);
    wait_out(b + 2);
    chk("R5 result0 after early done", outq[b[7:0]], VECS[4].r0);
    chk("R5 result1 after early done", outq[8'(b + 1)], VECS[4].r1);

    // R6: held full blocks all writes
    b = owp; lat = 1; full_force = 1'b1;
    push(VECS[1].w0); push(VECS[1].w1); push(VECS[1].w2); push(VECS[1].w3);
    repeat (20) @(negedge clk);
    chk("R6 no write while full", owp - b, 0);
    full_force = 1'b0;
    wait_out(b + 2);
    chk("R6 result0 after full", outq[b[7:0]], VECS[1].r0);
    chk("R6 result1 after full", outq[8'(b + 1)], VECS[1].r1);

    // R1: reset mid-request, next request restarts at index 0
    push(32'hDEAD_0001); push(32'hDEAD_0002);
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    iwp = irp;
    rst_n = 1'b1;
    @(negedge clk);
    run_req(VECS[3], "R1 after mid reset");

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule